// File: doc/BRIEF.md
# DMA completion interrupt aggregator

This block takes the transfer-complete strobes of sixteen DMA channels and folds them into a single interrupt line for a processor. A channel's data mover pulses its strobe for one cycle when its transfer count reaches zero. The aggregator does not tie a channel to a fixed flag. Instead, each channel presents a small completion-control field that holds an interrupt-enable bit and a 4-bit code. When enabled, the code steers that channel's completion into one of sixteen pending flags. Any channel may target any flag, and several channels may share one.

Software sees two registers on a simple single-cycle register bus. The pending register is read and write-one-to-clear. The enable register is read/write and masks the pending flags one for one. The interrupt output is a registered level: it is high whenever some pending flag is set and also enabled, and it stays high until software clears every such flag or masks it. A service routine reads pending and enable, handles each enabled flag starting from flag 0, and clears the flags it has served.

Top module: `dma_done_irq_agg`

## Requirements
- R1: After reset the pending register, the enable register and the interrupt output are all zero.
- R2: A channel has a 5-bit control field at bits [5c+4:5c] of `chan_ctl`. Its bit 4 is the interrupt enable and bits 3:0 are the code. When the channel's strobe is high and bit 4 is 1, pending flag number *code* is set at that clock edge. Every code from 0 to 15 reaches its own flag.
- R3: A strobe from a channel whose control bit 4 is 0 leaves the pending register unchanged.
- R4: Strobes from several channels in the same cycle set the union of their target flags. Two channels with the same code set that one flag.
- R5: A write to address 0 clears every pending flag whose write-data bit is 1. Flags whose write-data bit is 0 are left unchanged.
- R6: If a completion and a write-one-to-clear hit the same pending flag at the same edge, the flag ends up set.
- R7: A write to address 1 loads the enable register from the write data. A read at address 1 returns it.
- R8: At each clock edge, `irq` takes the OR over all flags of (pending AND enable) as it stood just before that edge. As a result it rises one cycle after the first enabled flag appears and falls one cycle after the last one goes away.
- R9: A read at address 0 returns the pending register. Reads at addresses 2 and 3 return zero, and writes to them change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_done | input | 16 | One-cycle completion strobe per channel |
| chan_ctl | input | 80 | Per-channel control fields, 5 bits each: bit 4 is the enable, bits 3:0 are the code |
| bus_addr | input | 2 | Register address: 0 pending, 1 enable |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Registered aggregate interrupt |

## Verification
The bench targets a clear and a completion landing on the same flag in one cycle. A design that let the clear win would lose an interrupt without any trace. It also drives two channels aimed at one code, and strobes from channels with interrupts disabled. Each of these would corrupt or invent pending flags if the steering or the gating were wrong. The one-cycle lag of the interrupt line is checked on both its rising and falling edges, so an unregistered output or an extra stage would be off by a cycle. Finally, writes to the unused addresses are checked, because a sloppy decode would let them clear flags or reload the mask.

// File: rtl/cia_pkg.sv
`timescale 1ns/1ps
package cia_pkg;
  localparam int CODE_W  = 4;
  localparam int NCODE   = 1 << CODE_W;
  localparam int CTL_W   = CODE_W + 1;
  localparam int IEN_POS = CODE_W;
  localparam int SEL_W   = 2;

  typedef logic [CTL_W-1:0]  ctl_field_t;
  typedef logic [CODE_W-1:0] code_t;
  typedef logic [NCODE-1:0]  code_vec_t;

  typedef enum logic [SEL_W-1:0] {
    SEL_PEND = 2'd0,
    SEL_MASK = 2'd1,
    SEL_RSV2 = 2'd2,
    SEL_RSV3 = 2'd3
  } reg_sel_e;

  function automatic logic ctl_irq_on(ctl_field_t f);
    return f[IEN_POS];
  endfunction

  function automatic code_t ctl_code(ctl_field_t f);
    return f[CODE_W-1:0];
  endfunction

  function automatic code_vec_t code_onehot(code_t c);
    code_vec_t v;
    v    = '0;
    v[c] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/cia_steer.sv
`timescale 1ns/1ps
module cia_steer
  import cia_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCH-1:0]     chan_done,
  input  logic [NCH*CTL_W-1:0] chan_ctl,
  output code_vec_t          set_vec
);
  code_vec_t contrib [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    ctl_field_t fld;
    assign fld        = chan_ctl[c*CTL_W +: CTL_W];
    assign contrib[c] = (chan_done[c] && ctl_irq_on(fld)) ? code_onehot(ctl_code(fld)) : '0;
  end

  always_comb begin
    set_vec = '0;
    for (int c = 0; c < NCH; c++) begin
      set_vec = set_vec | contrib[c];
    end
  end

  AST_SET_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |-> (|chan_done)); // R3
  AST_SET_WIDTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(set_vec) <= $countones(chan_done)); // R4
endmodule

// File: rtl/cia_pending.sv
`timescale 1ns/1ps
module cia_pending
  import cia_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  code_vec_t set_vec,
  input  code_vec_t clr_vec,
  output code_vec_t pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_vec) | set_vec;
  end

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((pend & $past(set_vec)) == $past(set_vec))); // R6
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~set_vec)) |=> ((pend & $past(clr_vec & ~set_vec)) == '0)); // R5
  AST_NO_PHANTOM_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(set_vec)) == '0)); // R3
endmodule

// File: rtl/cia_mask.sv
`timescale 1ns/1ps
module cia_mask
  import cia_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      mask_we,
  input  code_vec_t mask_wdata,
  output code_vec_t mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask <= '0;
    else if (mask_we) mask <= mask_wdata;
  end

  AST_MASK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask == $past(mask_wdata))); // R7
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask)); // R9
endmodule

// File: rtl/cia_regif.sv
`timescale 1ns/1ps
module cia_regif
  import cia_pkg::*;
(
  input  logic [SEL_W-1:0] bus_addr,
  input  logic             bus_wen,
  input  code_vec_t        bus_wdata,
  input  code_vec_t        pend,
  input  code_vec_t        mask,
  output code_vec_t        clr_vec,
  output logic             mask_we,
  output code_vec_t        rdata
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(bus_addr);

  always_comb begin
    clr_vec = '0;
    mask_we = 1'b0;
    rdata   = '0;
    unique case (sel)
      SEL_PEND: begin
        rdata = pend;
        if (bus_wen) clr_vec = bus_wdata;
      end
      SEL_MASK: begin
        rdata   = mask;
        mask_we = bus_wen;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dma_done_irq_agg.sv
`timescale 1ns/1ps
module dma_done_irq_agg
  import cia_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       chan_done,
  input  logic [NCH*CTL_W-1:0] chan_ctl,
  input  logic [SEL_W-1:0]     bus_addr,
  input  logic                 bus_wen,
  input  logic [NCODE-1:0]     bus_wdata,
  output logic [NCODE-1:0]     bus_rdata,
  output logic                 irq
);
  code_vec_t set_vec;
  code_vec_t clr_vec;
  code_vec_t pend;
  code_vec_t mask;
  logic      mask_we;
  code_vec_t live;

  cia_steer #(.NCH(NCH)) u_steer (
    .clk(clk), .rst_n(rst_n),
    .chan_done(chan_done), .chan_ctl(chan_ctl),
    .set_vec(set_vec)
  );

  cia_regif u_regif (
    .bus_addr(bus_addr), .bus_wen(bus_wen), .bus_wdata(bus_wdata),
    .pend(pend), .mask(mask),
    .clr_vec(clr_vec), .mask_we(mask_we), .rdata(bus_rdata)
  );

  cia_pending u_pend (
    .clk(clk), .rst_n(rst_n),
    .set_vec(set_vec), .clr_vec(clr_vec), .pend(pend)
  );

  cia_mask u_mask (
    .clk(clk), .rst_n(rst_n),
    .mask_we(mask_we), .mask_wdata(bus_wdata), .mask(mask)
  );

  assign live = pend & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |live;
  end

  AST_IRQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(pend & mask) != '0)); // R8
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((live != '0) && $past(live != '0)) |-> irq); // R8
  AST_RSV_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && bus_addr[1] && set_vec == '0) |=> ($stable(pend) && $stable(mask))); // R9
endmodule

// File: tb/sim_dma_done_irq_agg.sv
`timescale 1ns/1ps
module sim_dma_done_irq_agg;
  localparam int NCH = 16;
  localparam int FW  = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n;
  logic [NCH-1:0]    done;
  logic [4:0]        cfg [NCH];
  logic [NCH*FW-1:0] ctl;
  logic [1:0]        addr;
  logic              wen;
  logic [15:0]       wdata;
  logic [15:0]       rdata;
  logic              irq;

  always_comb begin
    for (int c = 0; c < NCH; c++) ctl[c*FW +: FW] = cfg[c];
  end

  dma_done_irq_agg #(.NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .chan_done(done), .chan_ctl(ctl),
    .bus_addr(addr), .bus_wen(wen), .bus_wdata(wdata),
    .bus_rdata(rdata), .irq(irq)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  logic [15:0] m_pend = '0;
  logic [15:0] m_en   = '0;
  logic        m_irq  = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference model: advance on one edge, then compare at the falling edge.
  task automatic cycle(string tag);
    logic [15:0] s;
    logic [15:0] clr;
    logic [15:0] n_pend;
    logic [15:0] n_en;
    logic        n_irq;
    logic [15:0] exp_rd;
    s = '0;
    for (int c = 0; c < NCH; c++) begin
      int code;
      code = int'(cfg[c]) % 16;
      if (done[c] && int'(cfg[c]) >= 16) s = s | (16'(1) << code);
    end
    clr    = (wen && addr == 2'd0) ? wdata : 16'h0;
    n_irq  = (m_pend & m_en) != 16'h0;
    n_pend = (m_pend & ~clr) | s;
    n_en   = (wen && addr == 2'd1) ? wdata : m_en;
    if (!rst_n) begin
      n_irq = 1'b0; n_pend = '0; n_en = '0;
    end
    @(posedge clk);
    m_pend = n_pend; m_en = n_en; m_irq = n_irq;
    @(negedge clk);
    chk({tag, " irq"}, 32'(irq), 32'(m_irq));
    case (addr)
      2'd0:    exp_rd = m_pend;
      2'd1:    exp_rd = m_en;
      default: exp_rd = 16'h0;
    endcase
    chk({tag, " rdata"}, 32'(rdata), 32'(exp_rd));
  endtask

  task automatic idle();
    done = '0; wen = 1'b0; wdata = '0;
  endtask

  task automatic set_cfg(int ch, logic ien, logic [3:0] code);
    cfg[ch] = {ien, code};
  endtask

  task automatic peek(string tag, logic [1:0] a, logic [15:0] exp);
    addr = a;
    #1;
    chk(tag, 32'(rdata), 32'(exp));
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr = 2'd0;
    for (int c = 0; c < NCH; c++) cfg[c] = 5'd0;
    idle();
    repeat (3) cycle("R1");
    rst_n = 1'b1;
    cycle("R1");
    peek("R1 pending", 2'd0, 16'h0);
    peek("R1 enable", 2'd1, 16'h0);
    chk("R1 irq", 32'(irq), 32'd0);

    // R2: channel 3, code 8
    addr = 2'd0;
    set_cfg(3, 1'b1, 4'd8); done[3] = 1'b1;
    cycle("R2");
    idle();
    peek("R2 code8", 2'd0, 16'h0100);
    cycle("R8");
    chk("R8 masked irq", 32'(irq), 32'd0);

    // R3: channel 5 disabled
    set_cfg(5, 1'b0, 4'd2); done[5] = 1'b1;
    cycle("R3");
    idle();
    peek("R3 disabled", 2'd0, 16'h0100);

    // R4: channels 0 and 9 share code 12, channel 10 code 4
    set_cfg(0, 1'b1, 4'd12); set_cfg(9, 1'b1, 4'd12); set_cfg(10, 1'b1, 4'd4);
    done[0] = 1'b1; done[9] = 1'b1; done[10] = 1'b1;
    cycle("R4");
    idle();
    peek("R4 union", 2'd0, 16'h1110);

    // R7: enable flag 12
    addr = 2'd1; wen = 1'b1; wdata = 16'h1000;
    cycle("R7");
    idle();
    peek("R7 readback", 2'd1, 16'h1000);
    chk("R8 lag rise", 32'(irq), 32'd0);
    cycle("R8");
    chk("R8 rise", 32'(irq), 32'd1);

    // R5: clear flag 4 only
    addr = 2'd0; wen = 1'b1; wdata = 16'h0010;
    cycle("R5");
    idle();
    peek("R5 w1c", 2'd0, 16'h1100);
    chk("R8 held", 32'(irq), 32'd1);

    // R6: completion on flag 12 collides with its clear
    addr = 2'd0; wen = 1'b1; wdata = 16'h1000; done[0] = 1'b1;
    cycle("R6");
    idle();
    peek("R6 set wins", 2'd0, 16'h1100);

    // R8: clear flag 12 and watch irq fall one cycle later
    addr = 2'd0; wen = 1'b1; wdata = 16'h1000;
    cycle("R8");
    idle();
    chk("R8 lag fall", 32'(irq), 32'd1);
    cycle("R8");
    chk("R8 fall", 32'(irq), 32'd0);
    peek("R5 cleared", 2'd0, 16'h0100);

    // R9: reserved addresses
    addr = 2'd2; wen = 1'b1; wdata = 16'hFFFF;
    cycle("R9");
    addr = 2'd3;
    cycle("R9");
    idle();
    peek("R9 rsv2", 2'd2, 16'h0);
    peek("R9 rsv3", 2'd3, 16'h0);
    peek("R9 pend kept", 2'd0, 16'h0100);
    peek("R9 en kept", 2'd1, 16'h1000);

    // R2: every code reaches its own flag
    addr = 2'd0; wen = 1'b1; wdata = 16'hFFFF;
    cycle("R5");
    idle();
    for (int k = 0; k < 16; k++) begin
      for (int c = 0; c < NCH; c++) cfg[c] = 5'd0;
      set_cfg(15 - k, 1'b1, 4'(k));
      done[15 - k] = 1'b1;
      addr = 2'd0;
      cycle("R2");
      idle();
      peek("R2 sweep", 2'd0, 16'((32'd1 << (k + 1)) - 1));
    end

    // Random traffic against the model
    for (int n = 0; n < 400; n++) begin
      for (int c = 0; c < NCH; c++) cfg[c] = 5'($urandom);
      done  = 16'($urandom) & 16'($urandom);
      wen   = ($urandom % 3) == 0;
      addr  = 2'($urandom);
      wdata = 16'($urandom);
      cycle("R8 random");
    end
    idle();
    cycle("R8");

    finished = 1;
    summary();
    $finish;
  end
endmodule